// File: doc/BRIEF.md
# Turbo Interleaver Address Generator

This block produces the read order for a turbo decoder's interleaver. It walks a linear feedback shift register through its state sequence and keeps only the states that fall inside the current block length. The result is a pseudo-random permutation of the addresses `0 .. N-1`, with one address per strobe. Two block lengths can be chosen: a long block of 12282 entries, which uses the full 14-stage register, and a short block of 6144 entries, which runs on the lower 13 stages.

A one-cycle `start_i` pulse latches the mode and clears the register. For the next two cycles the register takes in a fixed two-bit seed through the first stage's input multiplexer. After that it runs freely on its feedback polynomial. Every state then passes through a subtract-and-sign comparison against the block length. In-range states come out as `state - 1` with `valid_o` high. Out-of-range states are dropped without a strobe. When exactly N addresses have been issued, the generator stops and holds `done_o` high until the next start.

Top module: `turbo_ilv_agen`

## Requirements
- R1: While `rst` is high, and after reset until the first start, `valid_o` and `done_o` are 0 and `addr_o` is 0.
- R2: A start sampled on clock edge E0 clears the register. The seed is shifted in on edges E1 and E2, most significant seed bit first. With the default seed of binary 01, the register holds 1 after E2. No address is valid after E1 or after E2. The first address (0) is valid after E3.
- R3: In long mode the register shifts toward higher bit positions. The new bit 0 is bit13 ^ bit12 ^ bit11 ^ bit1. The state is evaluated once per cycle, in register order, starting from the seed.
- R4: A state is accepted only when the block length minus the state is non-negative and the state is nonzero. A state above N never produces a strobe, so every valid address is below N.
- R5: Each valid address equals the accepted register state minus one. It is presented one cycle after that state is evaluated.
- R6: `done_o` rises in the same cycle as the N-th valid address. After that no further address is valid, and `done_o` stays high until the next start.
- R7: In short mode (`mode_i` = 1), bit 13 is held at 0. The new bit 0 is bit12 ^ bit11 ^ bit10 ^ bit7. N is 6144.
- R8: `mode_i` is sampled only on the start edge. Changing it during a block has no effect on the sequence.
- R9: A start during a block abandons it. `valid_o` and `done_o` are 0 after the start edge, and the new block begins from the seed.
- R10: Within one block, every address from 0 to N-1 is issued exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a block |
| mode_i | input | 1 | Block length select: 0 = 12282, 1 = 6144 |
| addr_o | output | 14 | Interleaved address |
| valid_o | output | 1 | Address strobe |
| done_o | output | 1 | High once N addresses have been issued |

## Verification
The first strobe is due three edges after the start edge. From then on, each register state produces its accept or reject decision exactly one edge later. `done_o` rises together with the N-th strobe. The bench drives and samples on the falling edge. It counts the edges from the start pulse, then advances an independent polynomial model by one state per falling edge, so the presence or absence of each strobe and its address are checked in the exact cycle they are due. After completion, an abort or a mode change, the bench follows the outputs for further cycles to confirm that the stop, the restart and the mode latch took effect on the predicted edge.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned REG_W     = 14;
    localparam int unsigned DIFF_W    = REG_W + 1;
    localparam int unsigned LONG_LEN  = 12282;
    localparam int unsigned SHORT_LEN = 6144;
    localparam int unsigned SEED_LEN  = 2;
    localparam int unsigned SEED_CW   = $clog2(SEED_LEN + 1);

    typedef logic [REG_W-1:0] state_t;

    typedef enum logic {
        MODE_LONG  = 1'b0,
        MODE_SHORT = 1'b1
    } blk_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEED = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic   hit;
        state_t addr;
    } cand_t;

    // feedback bit entering stage 0 for the selected register length
    function automatic logic feedback(input state_t s, input blk_mode_e m);
        if (m == MODE_SHORT)
            return s[12] ^ s[11] ^ s[10] ^ s[7];
        return s[13] ^ s[12] ^ s[11] ^ s[1];
    endfunction

    function automatic state_t block_len(input blk_mode_e m);
        if (m == MODE_SHORT)
            return state_t'(SHORT_LEN);
        return state_t'(LONG_LEN);
    endfunction

endpackage

// File: rtl/ilv_shift_chain.sv
module ilv_shift_chain
    import ilv_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      advance,
    input  logic      seed_sel,
    input  logic      seed_bit,
    input  blk_mode_e mode,
    output state_t    state_o
);

    state_t q;
    state_t d;
    logic   fb;

    assign fb = feedback(q, mode);

    // per-stage input multiplexers
    for (genvar k = 0; k < W; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign d[k] = seed_sel ? seed_bit : fb;
        end else if (k == W - 1) begin : g_top
            assign d[k] = (mode == MODE_SHORT) ? 1'b0 : q[k-1];
        end else begin : g_mid
            assign d[k] = q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            q <= '0;
        else if (advance)
            q <= d;
    end

    assign state_o = q;

endmodule

// File: rtl/ilv_range_gate.sv
module ilv_range_gate
    import ilv_pkg::*;
(
    input  state_t value,
    input  state_t limit,
    output cand_t  cand
);

    logic [DIFF_W-1:0] diff;

    always_comb begin
        diff      = {1'b0, limit} - {1'b0, value};
        cand.hit  = ~diff[DIFF_W-1] && (value != '0);
        cand.addr = value - state_t'(1);
    end

endmodule

// File: rtl/ilv_seq_ctrl.sv
module ilv_seq_ctrl
    import ilv_pkg::*;
#(
    parameter logic [SEED_LEN-1:0] SEED_VAL = 2'b01
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      mode_i,
    input  logic      hit,
    output logic      clear,
    output logic      advance,
    output logic      seed_sel,
    output logic      seed_bit,
    output logic      accept,
    output logic      done,
    output blk_mode_e mode_q,
    output state_t    limit
);

    phase_e              phase;
    logic [SEED_LEN-1:0] seed_shr;
    logic [SEED_CW-1:0]  seed_cnt;
    state_t              count;
    logic                last;

    always_comb begin
        limit    = block_len(mode_q);
        clear    = start_i;
        seed_sel = (phase == PH_SEED);
        seed_bit = seed_shr[SEED_LEN-1];
        advance  = !start_i && (phase != PH_IDLE);
        accept   = !start_i && (phase == PH_RUN) && hit;
        last     = accept && (count == limit - state_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            seed_shr <= '0;
            seed_cnt <= '0;
            count    <= '0;
            done     <= 1'b0;
            mode_q   <= MODE_LONG;
        end else if (start_i) begin
            phase    <= PH_SEED;
            seed_shr <= SEED_VAL;
            seed_cnt <= '0;
            count    <= '0;
            done     <= 1'b0;
            mode_q   <= blk_mode_e'(mode_i);
        end else begin
            case (phase)
                PH_SEED: begin
                    seed_shr <= seed_shr << 1;
                    seed_cnt <= seed_cnt + SEED_CW'(1);
                    if (seed_cnt == SEED_CW'(SEED_LEN - 1))
                        phase <= PH_RUN;
                end
                PH_RUN: begin
                    if (accept)
                        count <= count + state_t'(1);
                    if (last) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/turbo_ilv_agen.sv
module turbo_ilv_agen
    import ilv_pkg::*;
#(
    parameter logic [SEED_LEN-1:0] SEED_VAL = 2'b01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              mode_i,
    output logic [REG_W-1:0]  addr_o,
    output logic              valid_o,
    output logic              done_o
);

    logic      clear_w, advance_w, seed_sel_w, seed_bit_w, accept_w, done_w;
    blk_mode_e mode_w;
    state_t    limit_w;
    state_t    state_w;
    cand_t     cand_w;
    state_t    addr_q;
    logic      valid_q;

    ilv_seq_ctrl #(.SEED_VAL(SEED_VAL)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .hit      (cand_w.hit),
        .clear    (clear_w),
        .advance  (advance_w),
        .seed_sel (seed_sel_w),
        .seed_bit (seed_bit_w),
        .accept   (accept_w),
        .done     (done_w),
        .mode_q   (mode_w),
        .limit    (limit_w)
    );

    ilv_shift_chain #(.W(REG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear_w),
        .advance  (advance_w),
        .seed_sel (seed_sel_w),
        .seed_bit (seed_bit_w),
        .mode     (mode_w),
        .state_o  (state_w)
    );

    ilv_range_gate u_gate (
        .value (state_w),
        .limit (limit_w),
        .cand  (cand_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= accept_w;
            if (accept_w)
                addr_q <= cand_w.addr;
        end
    end

    assign addr_o  = addr_q;
    assign valid_o = valid_q;
    assign done_o  = done_w;

endmodule

// File: rtl/ilv_agen_chk.sv
module ilv_agen_chk
    import ilv_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       valid_o,
    input logic       done_o,
    input state_t     addr_o,
    input state_t     limit,
    input blk_mode_e  mode_q
);

    logic [DIFF_W-1:0] vcnt;

    always_ff @(posedge clk) begin
        if (rst || start_i)
            vcnt <= '0;
        else if (valid_o)
            vcnt <= vcnt + DIFF_W'(1);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!valid_o && !done_o)); // R1

    AST_SEED_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        start_i |=> ##1 !valid_o); // R2

    AST_VALID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (addr_o < limit)); // R4

    AST_SHORT_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (valid_o && mode_q == MODE_SHORT) |-> !addr_o[REG_W-1]); // R7

    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (vcnt + DIFF_W'(1) == {1'b0, limit})); // R6

    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && !valid_o)); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!valid_o && !done_o)); // R9

endmodule

bind turbo_ilv_agen ilv_agen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .valid_o (valid_o),
    .done_o  (done_o),
    .addr_o  (addr_o),
    .limit   (limit_w),
    .mode_q  (mode_w)
);

// File: tb/test_turbo_ilv_agen.sv
module test_turbo_ilv_agen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [13:0] addr_o;
    logic        valid_o;
    logic        done_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    turbo_ilv_agen i_turbo_ilv_agen (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .mode_i  (mode_i),
        .addr_o  (addr_o),
        .valid_o (valid_o),
        .done_o  (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [13:0] ref_step(input logic [13:0] s, input bit short_m);
        if (short_m)
            return {1'b0, s[11:0], s[12] ^ s[11] ^ s[10] ^ s[7]};
        return {s[12:0], s[13] ^ s[12] ^ s[11] ^ s[1]};
    endfunction

    // start a block and follow it; abort_after > 0 leaves after that many cycles
    task automatic run_block(input bit short_m, input int abort_after, input bit wiggle);
        logic [13:0]    ref_s;
        logic [16383:0] seen;
        int             n;
        int             got;
        int             cyc;
        bit             exp_v;
        string          rq;
        n  = short_m ? 6144 : 12282;
        rq = short_m ? "R7" : "R3";
        @(negedge clk);
        start_i = 1'b1;
        mode_i  = short_m;
        @(negedge clk);
        start_i = 1'b0;
        check(!valid_o && !done_o, "R9", "outputs after start edge", {valid_o, done_o}, 0);
        if (wiggle) mode_i = ~short_m;
        @(negedge clk);
        check(!valid_o, "R2", "strobe after seed edge 1", valid_o, 0);
        @(negedge clk);
        check(!valid_o, "R2", "strobe after seed edge 2", valid_o, 0);
        @(negedge clk);
        check(valid_o && addr_o == 0, "R2", "first address", addr_o, 0);
        ref_s = 14'd1;
        seen  = '0;
        got   = 0;
        cyc   = 0;
        while (got < n && cyc < 20000 && (abort_after == 0 || cyc < abort_after)) begin
            exp_v = (ref_s != 0) && (int'(ref_s) <= n);
            check(valid_o == exp_v, wiggle ? "R8" : rq, "strobe timing", valid_o, exp_v);
            if (valid_o) begin
                check(int'(addr_o) < n, "R4", "address range", addr_o, n - 1);
                if (int'(addr_o) < n) begin
                    check(!seen[addr_o], "R10", "repeat address", addr_o, -1);
                    seen[addr_o] = 1'b1;
                end
            end
            if (exp_v) begin
                check(addr_o == ref_s - 14'd1, "R5", "address value", addr_o, ref_s - 1);
                got++;
                check(done_o == (got == n), "R6", "done with last strobe", done_o, got == n);
            end else begin
                check(!done_o, "R6", "early done", done_o, 0);
            end
            cyc++;
            if (got < n) begin
                ref_s = ref_step(ref_s, short_m);
                @(negedge clk);
            end
        end
        if (abort_after == 0) begin
            check(got == n, wiggle ? "R8" : "R10", "addresses issued", got, n);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                check(done_o && !valid_o, "R6", "hold after done", {done_o, valid_o}, 2);
            end
        end
        mode_i = 1'b0;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(!valid_o && !done_o && addr_o == 0, "R1", "during reset",
              {valid_o, done_o, addr_o}, 0);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!valid_o && !done_o && addr_o == 0, "R1", "idle after reset",
                  {valid_o, done_o, addr_o}, 0);
        end
    endtask

    task automatic test_reset_midrun();
        run_block(1'b1, 200, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!valid_o && !done_o, "R1", "reset mid block", {valid_o, done_o}, 0);
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(!valid_o && !done_o, "R1", "quiet after reset", {valid_o, done_o}, 0);
        end
    endtask

    initial begin
        test_reset();
        run_block(1'b0, 0, 1'b0);    // long block, R3
        run_block(1'b1, 0, 1'b0);    // short block, R7
        run_block(1'b0, 300, 1'b0);  // abandoned block
        run_block(1'b1, 0, 1'b1);    // restart, R9, with mode wiggled, R8
        run_block(1'b0, 0, 1'b1);    // long with mode wiggled, R8
        test_reset_midrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule